// File: doc/BRIEF.md
# Dual Frame Buffer Display Refresh Read Address Generator

This block generates read addresses for a display-refresh DMA channel. A control write sets the run bit. The block then walks forward through a frame buffer held in memory, in steps of 16-bit words. For each step it presents one request to a memory-port scheduler. A request is either an eight-beat burst or a single word. The block holds the request steady until the scheduler grants it, then moves to the next address. It never computes a write address, because the display side consumes the data directly.

Two frame buffers are described by a top address and an exclusive bottom address each. In single mode the walk returns to the top of buffer 1 each time it reaches the bottom of buffer 1. In dual mode the walk runs through buffer 1, then buffer 2, then back to buffer 1. A request never crosses a bottom address. When fewer than eight words remain before the bottom, the block issues single-word requests until it lands exactly on the bottom.

Each completed frame sets a sticky status bit. The interrupt output is that status bit gated by an enable bit. New limits and a new mode, written while a frame is in progress, take effect only at the next frame boundary (or at the next start). The request priority is a constant high value.

Top module: `fbscan_top`

## Requirements
- R1: One cycle after the edge that sets the run bit (control register at select 0, bit 0), the request goes valid. Its first address is the stored top address of buffer 1 (select 1).
- R2: A granted burst moves the address forward by BURST_LEN*2 bytes. A granted single moves it forward by 2 bytes. A request that is not granted leaves the address unchanged.
- R3: `req_burst` is 1 exactly when (bottom − address)/2 is at least BURST_LEN. No request extends past the bottom address of its buffer.
- R4: In single mode (control bit 1 = 0), when a granted request ends exactly on the bottom of buffer 1 (select 2), the next address is the top of buffer 1.
- R5: In dual mode (control bit 1 = 1), reaching the bottom of buffer 1 continues at the top of buffer 2 (select 3). Reaching the bottom of buffer 2 (select 4) continues at the top of buffer 1.
- R6: `req_prio` is always 1. `req_port` follows control bit 3.
- R7: The grant that completes a frame sets the frame-done status (control bit 4, read back at select 0). The bit stays set until software writes 1 to bit 4 of the control register.
- R8: `irq` equals the frame-done status AND the interrupt enable (control bit 2), with no added delay.
- R9: Changes to the top/bottom registers and to the mode bit made during a frame have no effect on the address sequence until the next frame boundary or the next start.
- R10: Clearing the run bit drops `req_valid` one cycle after the write edge.
- R11: All four address registers store bit 0 as zero and read back as written otherwise. An unmapped select reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1/2 top/bottom of buffer 1, 3/4 top/bottom of buffer 2 |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Read data for the selected register (combinational) |
| req_valid | output | 1 | Read request pending |
| req_addr | output | ADDR_W | Byte address of the request |
| req_burst | output | 1 | 1 = BURST_LEN-beat burst, 0 = single word |
| req_port | output | 1 | Memory source port select |
| req_prio | output | 1 | Channel priority, constant high |
| req_grant | input | 1 | Scheduler accepts the pending request at this edge |
| irq | output | 1 | End-of-frame interrupt |

## Verification
The request and the address update on the clock edge after a grant. A run-bit write shows on `req_valid` one edge later than the control register itself. Frame-done status and `irq` are visible right after the granting edge, and read data is combinational. The bench models every edge with the values that stood before it. It compares all outputs at the following falling edge, so the start delay, the boundary reload and the deferred register changes are all checked in their exact cycle. Sweeps cover frame lengths of 1 to 20 words, grant patterns with stalls, and mode changes made in the middle of a frame.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;

   // register select codes
   localparam logic [2:0] SEL_CTRL = 3'd0;
   localparam logic [2:0] SEL_TOP1 = 3'd1;
   localparam logic [2:0] SEL_BOT1 = 3'd2;
   localparam logic [2:0] SEL_TOP2 = 3'd3;
   localparam logic [2:0] SEL_BOT2 = 3'd4;

   // control bits 3..0 in this order; bit 4 is frame-done status
   typedef struct packed {
      logic port;
      logic ien;
      logic dual;
      logic run;
   } ctrl_t;

   localparam int STATUS_BIT = 4;

endpackage

// File: rtl/fbscan_regs.sv
module fbscan_regs
   import fbscan_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        sel,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] rdata,
   output ctrl_t             ctrl_o,
   output logic [ADDR_W-1:0] top1_o,
   output logic [ADDR_W-1:0] bot1_o,
   output logic [ADDR_W-1:0] top2_o,
   output logic [ADDR_W-1:0] bot2_o,
   input  logic              frame_done_i,
   output logic              status_o
);

   generate
      if (ADDR_W < 8) begin : g_bad_width
         $error("fbscan_regs: ADDR_W must be at least 8");
      end
   endgenerate

   localparam int CW = $bits(ctrl_t);

   logic [ADDR_W-1:0] aligned_wd;
   logic              clr_req;

   assign aligned_wd = {wdata[ADDR_W-1:1], 1'b0};
   assign clr_req    = wr_en && (sel == SEL_CTRL) && wdata[STATUS_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_o <= '0;
         top1_o <= '0;
         bot1_o <= '0;
         top2_o <= '0;
         bot2_o <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_CTRL: ctrl_o <= ctrl_t'(wdata[CW-1:0]);
            SEL_TOP1: top1_o <= aligned_wd;
            SEL_BOT1: bot1_o <= aligned_wd;
            SEL_TOP2: top2_o <= aligned_wd;
            SEL_BOT2: bot2_o <= aligned_wd;
            default: ;
         endcase
      end
   end

   // sticky frame-done, set wins over a clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)            status_o <= 1'b0;
      else if (frame_done_i) status_o <= 1'b1;
      else if (clr_req)      status_o <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_CTRL: rdata[CW:0] = {status_o, ctrl_o};
         SEL_TOP1: rdata = top1_o;
         SEL_BOT1: rdata = bot1_o;
         SEL_TOP2: rdata = top2_o;
         SEL_BOT2: rdata = bot2_o;
         default:  rdata = '0;
      endcase
   end

   assert_status_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o) |-> $past(frame_done_i));

   assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o && !clr_req) |=> status_o);

   assert_even_regs_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(top1_o[0] || bot1_o[0] || top2_o[0] || bot2_o[0]));

endmodule

// File: rtl/fbscan_walker.sv
module fbscan_walker #(
   parameter int ADDR_W    = 32,
   parameter int BURST_LEN = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              dual_i,
   input  logic [ADDR_W-1:0] top1_i,
   input  logic [ADDR_W-1:0] bot1_i,
   input  logic [ADDR_W-1:0] top2_i,
   input  logic [ADDR_W-1:0] bot2_i,
   input  logic              grant_i,
   output logic              valid_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              burst_o,
   output logic              frame_done_o
);

   generate
      if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_burst
         $error("fbscan_walker: BURST_LEN must be a power of two, at least 2");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] BURST_WORDS = ADDR_W'(BURST_LEN);
   localparam logic [ADDR_W-1:0] STEP_BURST  = ADDR_W'(BURST_LEN * 2);
   localparam logic [ADDR_W-1:0] STEP_SINGLE = ADDR_W'(2);

   logic              running;
   logic              in_fb2;
   logic [ADDR_W-1:0] cur_addr;
   logic [ADDR_W-1:0] act_top1, act_bot1, act_top2, act_bot2;

   logic [ADDR_W-1:0] cur_top, cur_bot, words_left, lin_next;
   logic              use_burst, hit_bottom, advance, go_fb2;

   assign cur_top    = in_fb2 ? act_top2 : act_top1;
   assign cur_bot    = in_fb2 ? act_bot2 : act_bot1;
   assign words_left = (cur_bot - cur_addr) >> 1;
   assign use_burst  = words_left >= BURST_WORDS;
   assign lin_next   = cur_addr + (use_burst ? STEP_BURST : STEP_SINGLE);
   assign hit_bottom = lin_next == cur_bot;
   assign advance    = running && grant_i;
   // the freshly loaded mode decides the follow-on buffer
   assign go_fb2     = !in_fb2 && dual_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running  <= 1'b0;
         in_fb2   <= 1'b0;
         cur_addr <= '0;
         act_top1 <= '0;
         act_bot1 <= '0;
         act_top2 <= '0;
         act_bot2 <= '0;
      end else begin
         running <= run_i;
         if (!running && run_i) begin
            act_top1 <= top1_i;
            act_bot1 <= bot1_i;
            act_top2 <= top2_i;
            act_bot2 <= bot2_i;
            cur_addr <= top1_i;
            in_fb2   <= 1'b0;
         end else if (advance) begin
            if (hit_bottom) begin
               act_top1 <= top1_i;
               act_bot1 <= bot1_i;
               act_top2 <= top2_i;
               act_bot2 <= bot2_i;
               cur_addr <= go_fb2 ? top2_i : top1_i;
               in_fb2   <= go_fb2;
            end else begin
               cur_addr <= lin_next;
            end
         end
      end
   end

   assign valid_o      = running;
   assign addr_o       = cur_addr;
   assign burst_o      = use_burst;
   assign frame_done_o = advance && hit_bottom;

   assert_first_top1_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> addr_o == $past(top1_i));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !grant_i && run_i) |=> ($stable(addr_o) && $stable(burst_o)));

   assert_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (addr_o >= cur_top && addr_o < cur_bot));

   assert_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !valid_o);

   assert_halfword_R11: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !addr_o[0]);

endmodule

// File: rtl/fbscan_top.sv
module fbscan_top
   import fbscan_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int BURST_LEN = 8,
   parameter bit IRQ_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   output logic              req_valid,
   output logic [ADDR_W-1:0] req_addr,
   output logic              req_burst,
   output logic              req_port,
   output logic              req_prio,
   input  logic              req_grant,
   output logic              irq
);

   ctrl_t             ctrl;
   logic [ADDR_W-1:0] top1, bot1, top2, bot2;
   logic              frame_done, status;

   fbscan_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (reg_wr),
      .sel          (reg_sel),
      .wdata        (reg_wdata),
      .rdata        (reg_rdata),
      .ctrl_o       (ctrl),
      .top1_o       (top1),
      .bot1_o       (bot1),
      .top2_o       (top2),
      .bot2_o       (bot2),
      .frame_done_i (frame_done),
      .status_o     (status)
   );

   fbscan_walker #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_walker (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_i        (ctrl.run),
      .dual_i       (ctrl.dual),
      .top1_i       (top1),
      .bot1_i       (bot1),
      .top2_i       (top2),
      .bot2_i       (bot2),
      .grant_i      (req_grant),
      .valid_o      (req_valid),
      .addr_o       (req_addr),
      .burst_o      (req_burst),
      .frame_done_o (frame_done)
   );

   assign req_port = ctrl.port;
   assign req_prio = 1'b1;

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= status && ctrl.ien;
         end
         assign irq = irq_q;
      end else begin : g_irq_direct
         assign irq = status && ctrl.ien;
      end
   endgenerate

   assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !IRQ_REG) |-> ctrl.ien);

endmodule

// File: tb/fbscan_top_bench.sv
module fbscan_top_bench;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [2:0]    reg_sel = '0;
   logic [AW-1:0] reg_wdata = '0;
   logic [AW-1:0] reg_rdata;
   logic          req_valid, req_burst, req_port, req_prio, irq;
   logic [AW-1:0] req_addr;
   logic          req_grant = 1'b0;

   always #5 clk = ~clk;

   fbscan_top #(.ADDR_W(AW), .BURST_LEN(8)) u_fbscan_top (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
      .req_addr(req_addr), .req_burst(req_burst), .req_port(req_port),
      .req_prio(req_prio), .req_grant(req_grant), .irq(irq)
   );

   int n_vec = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // register mirror (what software wrote)
   logic [AW-1:0] mr_t1 = '0, mr_b1 = '0, mr_t2 = '0, mr_b2 = '0;
   logic          mc_run = 0, mc_dual = 0, mc_ien = 0, mc_port = 0;
   // model of the walker state
   logic          m_running = 0, m_fb2 = 0, m_status = 0;
   logic [AW-1:0] m_addr = '0, ma_t1 = '0, ma_b1 = '0, ma_t2 = '0, ma_b2 = '0;
   string         m_tag = "R1";
   int            m_frames = 0;
   logic [AW-1:0] last_rdata;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input logic g, input logic we, input logic [2:0] a, input logic [AW-1:0] d);
      logic [AW-1:0] cb, lin;
      logic eb, clr, set;
      @(negedge clk);
      chk(req_valid == m_running, "R10", req_valid, m_running);
      if (m_running) begin
         cb = m_fb2 ? ma_b2 : ma_b1;
         eb = ((cb - m_addr) >> 1) >= 8;
         chk(req_addr == m_addr, m_tag, req_addr, m_addr);
         chk(req_burst == eb, "R3", req_burst, eb);
         chk(req_port == mc_port, "R6", req_port, mc_port);
      end
      chk(req_prio == 1'b1, "R6", req_prio, 1);
      chk(irq == (m_status & mc_ien), "R8", irq, m_status & mc_ien);
      reg_wr = we; reg_sel = a; reg_wdata = d; req_grant = g;
      #1 last_rdata = reg_rdata;
      @(posedge clk);
      // model the edge using the values that stood before it
      set = 0;
      clr = we && (a == 3'd0) && d[4];
      if (!m_running && mc_run) begin
         ma_t1 = mr_t1; ma_b1 = mr_b1; ma_t2 = mr_t2; ma_b2 = mr_b2;
         m_addr = mr_t1; m_fb2 = 0; m_tag = "R1";
      end else if (m_running && g) begin
         cb = m_fb2 ? ma_b2 : ma_b1;
         eb = ((cb - m_addr) >> 1) >= 8;
         lin = m_addr + (eb ? 16'd16 : 16'd2);
         if (lin == cb) begin
            set = 1; m_frames++;
            ma_t1 = mr_t1; ma_b1 = mr_b1; ma_t2 = mr_t2; ma_b2 = mr_b2;
            if (!m_fb2 && mc_dual) begin m_addr = mr_t2; m_fb2 = 1; m_tag = "R5"; end
            else begin m_addr = mr_t1; m_tag = m_fb2 ? "R5" : "R4"; m_fb2 = 0; end
         end else begin
            m_addr = lin; m_tag = "R2";
         end
      end
      m_running = mc_run;
      m_status = set ? 1'b1 : (clr ? 1'b0 : m_status);
      if (we) begin
         case (a)
            3'd0: begin mc_run = d[0]; mc_dual = d[1]; mc_ien = d[2]; mc_port = d[3]; end
            3'd1: mr_t1 = {d[AW-1:1], 1'b0};
            3'd2: mr_b1 = {d[AW-1:1], 1'b0};
            3'd3: mr_t2 = {d[AW-1:1], 1'b0};
            3'd4: mr_b2 = {d[AW-1:1], 1'b0};
            default: ;
         endcase
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [AW-1:0] d);
      step(1'b0, 1'b1, a, d);
   endtask

   task automatic rd(input logic [2:0] a, input logic [AW-1:0] exp, input string tag);
      step(1'b0, 1'b0, a, '0);
      chk(last_rdata == exp, tag, last_rdata, exp);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "WATCHDOG", 0, 1);
         summary();
      end
   end

   initial begin
      int f0;
      repeat (3) @(posedge clk);
      // reset state
      @(negedge clk);
      chk(req_valid == 1'b0, "R10", req_valid, 0);
      chk(irq == 1'b0, "R8", irq, 0);
      chk(reg_rdata == '0, "R7", reg_rdata, 0);
      rst_n = 1'b1;

      // R11: bit 0 dropped, unmapped select reads zero
      wr(3'd1, 16'h0101);
      rd(3'd1, 16'h0100, "R11");
      wr(3'd3, 16'h0401);
      rd(3'd3, 16'h0400, "R11");
      wr(3'd4, 16'h0410);
      rd(3'd4, 16'h0410, "R11");
      rd(3'd6, 16'h0000, "R11");

      // sweep frame length 1..20 words in single mode, grant every cycle
      for (int n = 1; n <= 20; n++) begin
         wr(3'd0, 16'h0000);
         wr(3'd2, 16'h0100 + 16'(2 * n));
         wr(3'd0, 16'h0005 | 16'(n[0] << 3));
         f0 = m_frames;
         for (int i = 0; i < 24; i++) step(1'b1, 1'b0, 3'd0, '0);
         chk(m_frames - f0 >= 2, "R4", m_frames - f0, 2);
         wr(3'd0, 16'h0015);            // clear status, keep running
      end

      // dual mode with stalls, limits changed mid-frame
      wr(3'd0, 16'h0000);
      wr(3'd2, 16'h0126);               // 19 words
      wr(3'd0, 16'h0007);               // run, dual, ien
      for (int i = 0; i < 30; i++) step(i % 3 != 0, 1'b0, 3'd0, '0);
      wr(3'd2, 16'h0130);               // R9: 24 words from next frame on
      wr(3'd3, 16'h0500);
      wr(3'd4, 16'h0520);
      for (int i = 0; i < 60; i++) step(i % 4 != 1, 1'b0, 3'd0, '0);
      wr(3'd0, 16'h0003);               // R9: mode kept, irq masked (R8)
      for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 3'd0, '0);
      wr(3'd0, 16'h0001);               // R9: back to single at next boundary
      for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 3'd0, '0);

      // R7 sticky status and write-1 clear while stopped
      wr(3'd0, 16'h0000);
      rd(3'd0, 16'h0010, "R7");
      wr(3'd0, 16'h0004);
      rd(3'd0, 16'h0014, "R7");
      wr(3'd0, 16'h0014);
      rd(3'd0, 16'h0004, "R7");
      step(1'b1, 1'b0, 3'd0, '0);
      step(1'b1, 1'b0, 3'd0, '0);
      chk(req_valid == 1'b0, "R10", req_valid, 0);

      done = 1'b1;
      summary();
   end

endmodule